// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a virtual address into a real address by fetching 8-byte translation entries from memory. A chain can have up to five tables: three region tables, one segment table and one page table. The type field of the root descriptor sets where the walk begins, so a shallow address space needs fewer memory reads. The address-space mode of the request selects the root descriptor. In secondary mode an instruction fetch uses the primary root, and a data access uses the secondary root.

The request and response sides each use a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that cycle until the response is taken, so only one translation is in flight. The response holds all of its fields until `rsp_ready` is seen high. The memory side issues one entry read at a time. `mem_req_valid` holds with a stable address until `mem_req_ready`, and the entry is taken on the single cycle that `mem_rsp_valid` is high. The three root descriptors are plain control inputs, sampled when a request is accepted.

Top module: `dat_walker`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the response handshake completes. While `rsp_ready` is low, `rsp_valid` and every response field hold. After reset `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0.
- R2: When `req_amode64`=0 the address is first ANDed with 0x7FFF_FFFF. When `req_xlate_en`=0 the block makes no memory read and returns the page-aligned (4 KiB) address with permissions 3'b111 and no fault.
- R3: `req_mode` 1 or 0 selects `root_primary`, 2 selects `root_secondary` and 3 selects `root_home`. The space identifier is 1 for primary, 2 for secondary and 3 for home.
- R4: The root type is descriptor bits [3:2]: 3 first-region, 2 second-region, 1 third-region, 0 segment. A second-region root needs address bits [63:53] zero, a third-region root needs [63:42] zero, and a segment root needs [63:31] zero. A violation gives fault code 1 with no memory read.
- R5: The walk starts at table index 3 minus the root type (0..2 region tables, 3 segment table, 4 page table) and the table origin is the root with its low 12 bits cleared. The entry address is origin + offset. The offsets are (va>>50)&0x3FF8, (va>>39)&0x3FF8, (va>>28)&0x3FF8 and (va>>17)&0x3FF8 for tables 0 to 3, and (va>>9)&0x7F8 for table 4.
- R6: An entry read from table k (k<4) must have type 3-k. It points to the next table at the entry with its low 12 bits cleared, or its low 11 bits cleared when k=3.
- R7: Bit 5 set in the root or in any region or segment entry gives fault code 2.
- R8: An entry type that does not match its table gives fault code 1.
- R9: Bit 4 set in the root or in a region or segment entry (and no earlier fault) ends the walk with real address equal to the page-aligned virtual address.
- R10: In a page entry, bit 10 set gives fault code 3. Otherwise the real address is the entry with its low 12 bits cleared, and bit 9 clears write permission. Permission bits are {execute, write, read}.
- R11: A write access (`req_acc`=1) whose final permissions lack write gives fault code 4.
- R12: On any fault, `rsp_raddr` and `rsp_perm` are 0. `rsp_tex` is the page-aligned virtual address ORed with the space identifier, plus 4 for a protection fault. On success `rsp_tex` is 0 and `rsp_fault` is 0.
- R13: In secondary mode a fetch (`req_acc`=2) uses the primary root with space identifier 1 and keeps only execute permission. A data access uses the secondary root and loses execute permission. Other modes keep their permissions.
- R14: Only one memory read is outstanding at a time. `mem_req_valid` holds with a stable, 8-byte aligned `mem_addr` until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, can take a request |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | 0 read, 1 write, 2 fetch |
| req_mode | input | 2 | Address-space mode |
| req_amode64 | input | 1 | 64-bit addressing when 1, 31-bit when 0 |
| req_xlate_en | input | 1 | Translation enable |
| root_primary | input | 64 | Primary root descriptor |
| root_secondary | input | 64 | Secondary root descriptor |
| root_home | input | 64 | Home root descriptor |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 64 | Entry address |
| mem_rsp_valid | input | 1 | Entry data valid (one cycle) |
| mem_rsp_data | input | 64 | Entry data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_raddr | output | 64 | Real address |
| rsp_perm | output | 3 | {execute, write, read} |
| rsp_fault | output | 3 | 0 none, 1 spec, 2 segment, 3 page, 4 protection |
| rsp_tex | output | 64 | Translation-exception word |

## Verification
The bench varies the root type so that the walk starts at each depth. It checks the number of memory reads per request, because a design that started at the wrong level or indexed with the wrong shift would read a different count or a different address and return the wrong frame. It sends addresses just past each root type's range limit; a missing or off-by-one range check would walk the tables instead of faulting with no read. In secondary mode it sends a fetch whose address only the primary root can map; a design that ignored the fetch/data split would fault or return the wrong permissions. It also covers read-only pages for both reads and writes, invalid and real-space bits at root, middle and leaf levels, and 31-bit masking. A wrong space identifier or a missing protection bit shows up in the exception word.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int VA_W     = 64;
  localparam int PG_SHIFT = 12;
  localparam int N_TBL    = 5;
  localparam int LVL_W    = $clog2(N_TBL);
  localparam int D_INV    = 5;
  localparam int D_REAL   = 4;
  localparam int P_INV    = 10;
  localparam int P_RO     = 9;
  localparam logic [VA_W-1:0] PG_MASK  = ~((VA_W'(1) << PG_SHIFT) - VA_W'(1));
  localparam logic [VA_W-1:0] SEG_MASK = ~((VA_W'(1) << (PG_SHIFT-1)) - VA_W'(1));

  typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_IF = 2'd2} acc_e;
  typedef enum logic [2:0] {FLT_NONE = 3'd0, FLT_SPEC = 3'd1, FLT_SEG = 3'd2,
                            FLT_PAGE = 3'd3, FLT_PROT = 3'd4} flt_e;
  typedef enum logic [1:0] {EV_NEXT, EV_REAL, EV_LEAF, EV_FAULT} ev_e;

  // byte offset of the entry inside table 'lvl' for address 'va'
  function automatic logic [VA_W-1:0] tbl_offset(input logic [LVL_W-1:0] lvl,
                                                 input logic [VA_W-1:0] va);
    case (lvl)
      LVL_W'(0): tbl_offset = (va >> 50) & VA_W'(64'h3FF8);
      LVL_W'(1): tbl_offset = (va >> 39) & VA_W'(64'h3FF8);
      LVL_W'(2): tbl_offset = (va >> 28) & VA_W'(64'h3FF8);
      LVL_W'(3): tbl_offset = (va >> 17) & VA_W'(64'h3FF8);
      default:   tbl_offset = (va >> 9)  & VA_W'(64'h07F8);
    endcase
  endfunction
endpackage

// File: rtl/walk_root_sel.sv
module walk_root_sel
  import walk_pkg::*;
(
  input  logic [1:0]      mode,
  input  logic [1:0]      acc,
  input  logic [VA_W-1:0] root_p,
  input  logic [VA_W-1:0] root_s,
  input  logic [VA_W-1:0] root_h,
  output logic [VA_W-1:0] root,
  output logic [1:0]      sid,
  output logic            strip_rw,
  output logic            strip_x
);
  always_comb begin
    root     = root_p;
    sid      = 2'd1;
    strip_rw = 1'b0;
    strip_x  = 1'b0;
    case (mode)
      2'd2: begin
        if (acc == ACC_IF) begin
          strip_rw = 1'b1;
        end else begin
          root    = root_s;
          sid     = 2'd2;
          strip_x = 1'b1;
        end
      end
      2'd3: begin
        root = root_h;
        sid  = 2'd3;
      end
      default: ;
    endcase
  end

  always_comb begin
    assert_split_exclusive_R13: assert (!(strip_rw && strip_x));
  end
endmodule

// File: rtl/walk_entry_eval.sv
module walk_entry_eval
  import walk_pkg::*;
(
  input  logic [VA_W-1:0]  entry,
  input  logic [LVL_W-1:0] lvl,
  output ev_e              ev,
  output flt_e             flt,
  output logic [LVL_W-1:0] nxt_lvl,
  output logic [VA_W-1:0]  nxt_org,
  output logic [VA_W-1:0]  frame,
  output logic             ro
);
  logic is_page;
  assign is_page = (lvl >= LVL_W'(N_TBL-1));

  always_comb begin
    ev      = EV_NEXT;
    flt     = FLT_NONE;
    nxt_lvl = lvl + LVL_W'(1);
    nxt_org = (lvl == LVL_W'(N_TBL-2)) ? (entry & SEG_MASK) : (entry & PG_MASK);
    frame   = entry & PG_MASK;
    ro      = 1'b0;
    if (is_page) begin
      if (entry[P_INV]) begin
        ev  = EV_FAULT;
        flt = FLT_PAGE;
      end else begin
        ev = EV_LEAF;
        ro = entry[P_RO];
      end
    end else if (entry[D_INV]) begin
      ev  = EV_FAULT;
      flt = FLT_SEG;
    end else if (entry[3:2] != ~lvl[1:0]) begin
      ev  = EV_FAULT;
      flt = FLT_SPEC;
    end else if (entry[D_REAL]) begin
      ev = EV_REAL;
    end
  end
endmodule

// File: rtl/dat_walker.sv
module dat_walker
  import walk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  input  logic [1:0]      req_acc,
  input  logic [1:0]      req_mode,
  input  logic            req_amode64,
  input  logic            req_xlate_en,
  input  logic [VA_W-1:0] root_primary,
  input  logic [VA_W-1:0] root_secondary,
  input  logic [VA_W-1:0] root_home,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [VA_W-1:0] mem_addr,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [VA_W-1:0] rsp_raddr,
  output logic [2:0]      rsp_perm,
  output logic [2:0]      rsp_fault,
  output logic [VA_W-1:0] rsp_tex
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_RSP} st_e;
  st_e st;

  logic [VA_W-1:0]  va_q, org_q;
  logic [LVL_W-1:0] lvl_q;
  logic [1:0]       sid_q, acc_q;
  logic             srw_q, sx_q;

  // request-side decode
  logic [VA_W-1:0] va_m, va_pg, root;
  logic [1:0]      sid_l;
  logic            srw_l, sx_l, range_bad;

  assign va_m  = req_amode64 ? req_va : (req_va & VA_W'(64'h7FFF_FFFF));
  assign va_pg = va_m & PG_MASK;

  walk_root_sel u_root (
    .mode(req_mode), .acc(req_acc), .root_p(root_primary), .root_s(root_secondary),
    .root_h(root_home), .root(root), .sid(sid_l), .strip_rw(srw_l), .strip_x(sx_l)
  );

  always_comb begin
    case (root[3:2])
      2'd2:    range_bad = |va_m[63:53];
      2'd1:    range_bad = |va_m[63:42];
      2'd0:    range_bad = |va_m[63:31];
      default: range_bad = 1'b0;
    endcase
  end

  // entry evaluation
  ev_e              ev;
  flt_e             ev_flt;
  logic [LVL_W-1:0] ev_lvl;
  logic [VA_W-1:0]  ev_org, ev_frame;
  logic             ev_ro;

  walk_entry_eval u_eval (
    .entry(mem_rsp_data), .lvl(lvl_q), .ev(ev), .flt(ev_flt), .nxt_lvl(ev_lvl),
    .nxt_org(ev_org), .frame(ev_frame), .ro(ev_ro)
  );

  // current-context mux: live inputs in idle, latched copy during a walk
  logic            idle;
  logic [VA_W-1:0] c_va;
  logic [1:0]      c_sid, c_acc;
  logic            c_srw, c_sx;
  assign idle  = (st == S_IDLE);
  assign c_va  = idle ? va_pg : va_q;
  assign c_sid = idle ? sid_l : sid_q;
  assign c_acc = idle ? req_acc : acc_q;
  assign c_srw = idle ? srw_l : srw_q;
  assign c_sx  = idle ? sx_l : sx_q;

  logic             fin, walk, plain, ro;
  flt_e             flt;
  logic [VA_W-1:0]  fin_addr, n_org;
  logic [LVL_W-1:0] n_lvl;
  logic [2:0]       perm;

  always_comb begin
    fin = 1'b0; walk = 1'b0; plain = 1'b0; ro = 1'b0;
    flt = FLT_NONE; fin_addr = '0; n_lvl = lvl_q; n_org = org_q;
    if (idle && req_valid) begin
      if (!req_xlate_en) begin
        fin = 1'b1; plain = 1'b1; fin_addr = va_pg;
      end else if (range_bad) begin
        fin = 1'b1; flt = FLT_SPEC;
      end else if (root[D_INV]) begin
        fin = 1'b1; flt = FLT_SEG;
      end else if (root[D_REAL]) begin
        fin = 1'b1; fin_addr = va_pg;
      end else begin
        walk = 1'b1; n_lvl = {1'b0, ~root[3:2]}; n_org = root & PG_MASK;
      end
    end else if (st == S_WAIT && mem_rsp_valid) begin
      case (ev)
        EV_NEXT: begin walk = 1'b1; n_lvl = ev_lvl; n_org = ev_org; end
        EV_REAL: begin fin = 1'b1; fin_addr = va_q; end
        EV_LEAF: begin fin = 1'b1; fin_addr = ev_frame; ro = ev_ro; end
        default: begin fin = 1'b1; flt = ev_flt; end
      endcase
    end
    if (plain) perm = 3'b111;
    else       perm = {1'b1, ~ro, 1'b1} & {~c_sx, ~c_srw, ~c_srw};
    if (fin && !plain && flt == FLT_NONE && c_acc == ACC_WR && !perm[1]) flt = FLT_PROT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va_q <= '0; org_q <= '0; lvl_q <= '0; sid_q <= '0; acc_q <= '0;
      srw_q <= 1'b0; sx_q <= 1'b0;
      rsp_raddr <= '0; rsp_perm <= '0; rsp_fault <= '0; rsp_tex <= '0;
    end else begin
      if (idle && req_valid) begin
        va_q <= va_pg; sid_q <= sid_l; acc_q <= req_acc; srw_q <= srw_l; sx_q <= sx_l;
      end
      if (walk) begin
        lvl_q <= n_lvl; org_q <= n_org; st <= S_RD;
      end
      if (fin) begin
        st        <= S_RSP;
        rsp_fault <= flt;
        rsp_raddr <= (flt == FLT_NONE) ? fin_addr : '0;
        rsp_perm  <= (flt == FLT_NONE) ? perm : 3'b000;
        rsp_tex   <= (flt == FLT_NONE) ? '0
                   : (c_va | {{(VA_W-3){1'b0}}, (flt == FLT_PROT), c_sid});
      end
      if (st == S_RD && mem_req_ready) st <= S_WAIT;
      if (st == S_RSP && rsp_ready) st <= S_IDLE;
    end
  end

  assign req_ready     = idle;
  assign mem_req_valid = (st == S_RD);
  assign mem_addr      = org_q + tbl_offset(lvl_q, va_q);
  assign rsp_valid     = (st == S_RSP);

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  assert_rsp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_raddr) && $stable(rsp_fault)
      && $stable(rsp_tex) && $stable(rsp_perm));
  assert_memreq_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));
  assert_entry_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_addr[2:0] == 3'b000);
  assert_ok_page_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == FLT_NONE |-> rsp_raddr[PG_SHIFT-1:0] == '0);
  assert_tex_space_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != FLT_NONE |-> rsp_tex[1:0] != 2'b00);
endmodule

// File: tb/dat_walker_tb.sv
module dat_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = '0, req_mode = '0;
  logic        req_amode64 = 1'b1, req_xlate_en = 1'b0;
  logic [63:0] root_primary = '0, root_secondary = '0, root_home = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [63:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [63:0] rsp_raddr, rsp_tex;
  logic [2:0]  rsp_perm, rsp_fault;

  dat_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_acc(req_acc), .req_mode(req_mode), .req_amode64(req_amode64),
    .req_xlate_en(req_xlate_en), .root_primary(root_primary), .root_secondary(root_secondary),
    .root_home(root_home), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_raddr(rsp_raddr), .rsp_perm(rsp_perm),
    .rsp_fault(rsp_fault), .rsp_tex(rsp_tex)
  );

  typedef struct {
    logic [2:0]  flt;
    logic [63:0] raddr;
    logic [2:0]  perm;
    logic [63:0] tex;
    int          reads;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] mem [logic [63:0]];
  int checks = 0, fails = 0, cyc = 0, total_reads = 0, base_reads = 0;
  logic        pend = 1'b0;
  logic [63:0] paddr = '0;
  int          dly = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] toff(input int j, input logic [63:0] va);
    case (j)
      0: return (va >> 50) & 64'h3FF8;
      1: return (va >> 39) & 64'h3FF8;
      2: return (va >> 28) & 64'h3FF8;
      3: return (va >> 17) & 64'h3FF8;
      default: return (va >> 9) & 64'h7F8;
    endcase
  endfunction

  // memory model with back-pressure and two-cycle read latency
  always @(posedge clk) begin
    cyc++;
    mem_req_ready <= (cyc % 3) != 2;
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (dly == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem.exists(paddr) ? mem[paddr] : 64'h0;
        pend <= 1'b0;
      end else dly--;
    end
    if (rst_n && mem_req_valid && mem_req_ready) begin
      total_reads++;
      pend  <= 1'b1;
      paddr <= mem_addr;
      dly   = 1;
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    rsp_ready = (cyc % 4) != 1;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R1", "unexpected response", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_fault == e.flt,   e.tag, "fault", 64'(rsp_fault), 64'(e.flt));
        chk(rsp_raddr == e.raddr, e.tag, "raddr", rsp_raddr, e.raddr);
        chk(rsp_perm == e.perm,   e.tag, "perm",  64'(rsp_perm), 64'(e.perm));
        chk(rsp_tex == e.tex,     e.tag, "tex",   rsp_tex, e.tex);
        chk(total_reads - base_reads == e.reads, e.tag, "reads",
            64'(total_reads - base_reads), 64'(e.reads));
      end
      base_reads = total_reads;
    end
  end

  task automatic send(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] mode,
                      input logic a64, input logic en, input logic [2:0] flt,
                      input logic [63:0] raddr, input logic [2:0] perm,
                      input logic [63:0] tex, input int reads, input string tag);
    exp_t e;
    e.flt = flt; e.raddr = raddr; e.perm = perm; e.tex = tex; e.reads = reads; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc; req_mode = mode;
    req_amode64 = a64; req_xlate_en = en;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0 || sb.size() == 0, "R1", "busy after accept", 64'(req_ready), 64'd0);
    while (sb.size() != 0) @(negedge clk);
  endtask

  localparam logic [63:0] VA_A = 64'h0012_3000, VA_B = 64'h0012_5000, VA_C = 64'h0012_7000;
  localparam logic [63:0] VA_D = 64'h0030_0000, VA_E = 64'h0040_0000, VA_F = 64'h0050_1234;
  localparam logic [63:0] VA_S = 64'h0000_0123_4567_8000, VA_T = 64'h0000_0200_0000_0000;
  localparam logic [63:0] VA_BIG = 64'h0000_0400_0000_0000, VA_H = 64'h1234_5678_9ABC_D000;

  initial begin
    // primary: segment root at 0x10000, page table at 0x20000
    mem[64'h10000 + toff(3, VA_A)] = 64'h20000;
    mem[64'h20000 + toff(4, VA_A)] = 64'hABCD_E000;
    mem[64'h20000 + toff(4, VA_B)] = 64'h5555_5200;
    mem[64'h20000 + toff(4, VA_C)] = 64'h400;
    mem[64'h10000 + toff(3, VA_D)] = 64'h20;
    mem[64'h10000 + toff(3, VA_E)] = 64'h30004;
    mem[64'h10000 + toff(3, VA_F)] = 64'h10;
    // secondary: third-region root at 0x40000
    mem[64'h40000 + toff(2, VA_S)] = 64'h50004;
    mem[64'h50000 + toff(3, VA_S)] = 64'h60000;
    mem[64'h60000 + toff(4, VA_S)] = 64'h7_7777_7000;
    mem[64'h40000 + toff(2, VA_T)] = 64'h50000;
    // home: first-region root at 0x80000, five levels
    mem[64'h80000 + toff(0, VA_H)] = 64'h9000C;
    mem[64'h90000 + toff(1, VA_H)] = 64'hA0008;
    mem[64'hA0000 + toff(2, VA_H)] = 64'hB0004;
    mem[64'hB0000 + toff(3, VA_H)] = 64'hC0000;
    mem[64'hC0000 + toff(4, VA_H)] = 64'h1_2345_6000;

    root_primary   = 64'h10000;
    root_secondary = 64'h40004;
    root_home      = 64'h8000C;

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset req_ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R14", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    send(64'h1234_5678_9ABC_DEF0, 2'd0, 2'd1, 1'b1, 1'b0, 3'd0,
         64'h1234_5678_9ABC_D000, 3'b111, 64'h0, 0, "R2 off 64-bit");
    send(64'h1234_5678_9ABC_DEF0, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0,
         64'h1ABC_D000, 3'b111, 64'h0, 0, "R2 off 31-bit");
    send(VA_A, 2'd0, 2'd1, 1'b1, 1'b1, 3'd0, 64'hABCD_E000, 3'b111, 64'h0, 2, "R3 R5 R6 primary read");
    send(VA_A, 2'd1, 2'd0, 1'b1, 1'b1, 3'd0, 64'hABCD_E000, 3'b111, 64'h0, 2, "R3 mode0 write");
    send(VA_B, 2'd0, 2'd1, 1'b1, 1'b1, 3'd0, 64'h5555_5000, 3'b101, 64'h0, 2, "R10 ro read");
    send(VA_B, 2'd1, 2'd1, 1'b1, 1'b1, 3'd4, 64'h0, 3'b000, 64'h12_5005, 2, "R11 R12 ro write");
    send(VA_C, 2'd0, 2'd1, 1'b1, 1'b1, 3'd3, 64'h0, 3'b000, 64'h12_7001, 2, "R10 R12 page invalid");
    send(VA_D, 2'd0, 2'd1, 1'b1, 1'b1, 3'd2, 64'h0, 3'b000, 64'h30_0001, 1, "R7 segment invalid");
    send(VA_E, 2'd0, 2'd1, 1'b1, 1'b1, 3'd1, 64'h0, 3'b000, 64'h40_0001, 1, "R8 R6 type mismatch");
    send(VA_F, 2'd0, 2'd1, 1'b1, 1'b1, 3'd0, 64'h50_1000, 3'b111, 64'h0, 1, "R9 entry real");
    send(64'h8000_0000, 2'd0, 2'd1, 1'b1, 1'b1, 3'd1, 64'h0, 3'b000, 64'h8000_0001, 0, "R4 segment range");
    send(64'hFFFF_FFFF_8012_3456, 2'd0, 2'd1, 1'b0, 1'b1, 3'd0, 64'hABCD_E000, 3'b111, 64'h0, 2,
         "R2 31-bit walk");
    send(VA_S, 2'd0, 2'd2, 1'b1, 1'b1, 3'd0, 64'h7_7777_7000, 3'b011, 64'h0, 3, "R13 R14 secondary data");
    send(VA_S, 2'd1, 2'd2, 1'b1, 1'b1, 3'd0, 64'h7_7777_7000, 3'b011, 64'h0, 3, "R13 secondary write");
    send(VA_A, 2'd2, 2'd2, 1'b1, 1'b1, 3'd0, 64'hABCD_E000, 3'b100, 64'h0, 2, "R13 secondary fetch");
    send(VA_S, 2'd2, 2'd2, 1'b1, 1'b1, 3'd1, 64'h0, 3'b000, VA_S | 64'h1, 0, "R13 R12 fetch via primary");
    send(VA_T, 2'd0, 2'd2, 1'b1, 1'b1, 3'd1, 64'h0, 3'b000, VA_T | 64'h2, 1, "R8 region type");
    send(VA_BIG, 2'd0, 2'd2, 1'b1, 1'b1, 3'd1, 64'h0, 3'b000, VA_BIG | 64'h2, 0, "R4 region3 range");
    send(VA_H, 2'd2, 2'd3, 1'b1, 1'b1, 3'd0, 64'h1_2345_6000, 3'b111, 64'h0, 5, "R5 home five levels");
    root_home = 64'h80008;
    send(64'h0020_0000_0000_0000, 2'd0, 2'd3, 1'b1, 1'b1, 3'd1, 64'h0, 3'b000,
         64'h0020_0000_0000_0003, 0, "R4 region2 range");
    root_home = 64'h8002C;
    send(VA_H, 2'd0, 2'd3, 1'b1, 1'b1, 3'd2, 64'h0, 3'b000, VA_H | 64'h3, 0, "R7 root invalid");
    root_home = 64'h10;
    send(64'h7000_1234, 2'd1, 2'd3, 1'b1, 1'b1, 3'd0, 64'h7000_1000, 3'b111, 64'h0, 0, "R9 root real");

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule